// File: doc/BRIEF.md
# Debug Access-Port Control Register Block

This block sits behind the access-port channel of a debug port and answers only the accesses aimed at its own access-port number. It decodes three things: the access-port number, which is the top byte of the debug port's select word; the bank number, which is bits 7:4 of that word; and the two word-address bits A[3:2]. From these it serves three registers. The first is a read-only status word that mirrors the flash erase acknowledge and the secure input. The second is a three-bit control register. The third is a fixed identification word.

The control register drives three commands. Bit 0 is a flash mass-erase request, and the flash side clears it by answering with an erase-done handshake. Bit 1 is a debug-disable level. Bit 2 is a core halt request. When the device is secured, the debug-disable and halt bits are locked, but a mass erase can still be commanded. When the erase is not allowed, the request is swallowed: bit 0 stays set until the next reset, and the flash controller receives nothing.

Every access is a single cycle with a valid strobe. By default, read data is registered and appears in the cycle after the access.

Top module: `dbgap_regs`

## Requirements
- R1: The block responds only when `ap_sel` equals 8'h01. Any other `ap_sel`, or a bank/address combination that maps to no register, reads as zero and ignores writes.
- R2: The register map is as follows. Bank 4'h0 with A[3:2]=2'b00 is the status register. Bank 4'h0 with A[3:2]=2'b01 is the control register, with bit 0 = erase, bit 1 = debug disable and bit 2 = halt, and zeros above. Bank 4'hF with A[3:2]=2'b11 reads 32'h001C_0000.
- R3: Read data is registered. It appears in the cycle after a valid read and holds until the next valid read.
- R4: Status bit 0 mirrors `erase_ack` and status bit 1 mirrors `secure`, with all other bits zero. Writing to the status register changes nothing.
- R5: Writing 1 to control bit 0 while it is clear sets the bit. If `erase_allow` is high, the same write also produces an `erase_req` pulse exactly one cycle wide in the cycle after the write.
- R6: After a granted request, bit 0 clears in the cycle after `erase_done` is sampled high. Writing 0 to the bit does not clear it, and writing 1 while it is set issues no new request.
- R7: If `erase_allow` is low when bit 0 is set, no request is issued, `erase_done` is ignored, and the bit stays set until reset.
- R8: Control bits 1 and 2 take the written value only while `secure` is low. They drive `dbg_disable` and `halt_req`, and writes made while `secure` is high leave them unchanged. Bit 0 stays commandable while secured.
- R9: Reset clears all control bits, `erase_req`, `dbg_disable`, `halt_req` and `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | One-cycle access strobe |
| acc_rnw | input | 1 | 1 = read, 0 = write |
| ap_sel | input | 8 | Access-port number from select word bits 31:24 |
| bank_sel | input | 4 | Bank number from select word bits 7:4 |
| word_addr | input | 2 | Register address A[3:2] |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |
| secure | input | 1 | Device secured |
| erase_allow | input | 1 | Mass erase permitted by enable and security settings |
| erase_ack | input | 1 | Flash erase acknowledge, mirrored in status |
| erase_done | input | 1 | Flash reports the mass erase finished |
| erase_req | output | 1 | One-cycle mass-erase request |
| dbg_disable | output | 1 | Debug disable level |
| halt_req | output | 1 | Core halt request level |

## Verification
The bench builds the block with its default parameters: access-port number 8'h01, a 32-bit data path and registered read data. With these values, every combination of four access-port numbers, all sixteen banks and all four word addresses can be swept in a few thousand cycles. That covers each mapped register and every unmapped hole, for reads and for writes. The erase, lock and halt sequences are then driven with `secure` and `erase_allow` in each state, and the expected register contents are computed from a three-bit model held in the bench.

// File: rtl/dbgap_pkg.sv
package dbgap_pkg;

   typedef enum logic [1:0] {
      RK_NONE = 2'd0,
      RK_STAT = 2'd1,
      RK_CTRL = 2'd2,
      RK_ID   = 2'd3
   } regkind_t;

   localparam int CTRL_W = 3;

endpackage

// File: rtl/dbgap_decode.sv
module dbgap_decode
   import dbgap_pkg::*;
#(
   parameter logic [7:0] AP_ID     = 8'h01,
   parameter logic [3:0] BANK_MAIN = 4'h0,
   parameter logic [3:0] BANK_ID   = 4'hF
) (
   input  logic       acc_valid,
   input  logic       acc_rnw,
   input  logic [7:0] ap_sel,
   input  logic [3:0] bank_sel,
   input  logic [1:0] word_addr,
   output regkind_t   kind,
   output logic       rd_en,
   output logic       ctrl_wr
);

   logic hit;

   always_comb begin
      hit  = acc_valid && (ap_sel == AP_ID);
      kind = RK_NONE;
      if (hit) begin
         if (bank_sel == BANK_MAIN && word_addr == 2'b00)    kind = RK_STAT;
         else if (bank_sel == BANK_MAIN && word_addr == 2'b01) kind = RK_CTRL;
         else if (bank_sel == BANK_ID && word_addr == 2'b11)   kind = RK_ID;
      end
      rd_en   = acc_valid && acc_rnw;
      ctrl_wr = !acc_rnw && (kind == RK_CTRL);
   end

endmodule

// File: rtl/dbgap_ctrl.sv
module dbgap_ctrl
   import dbgap_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wbits,
   input  logic              secure,
   input  logic              erase_allow,
   input  logic              erase_done,
   output logic [CTRL_W-1:0] ctl_q,
   output logic              erase_pend,
   output logic              erase_req
);

   logic start;

   assign start = wr_en && wbits[0] && !ctl_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q      <= '0;
         erase_pend <= 1'b0;
         erase_req  <= 1'b0;
      end else begin
         erase_req <= start && erase_allow;
         if (start) begin
            ctl_q[0]   <= 1'b1;
            erase_pend <= erase_allow;
         end else if (erase_pend && erase_done) begin
            ctl_q[0]   <= 1'b0;
            erase_pend <= 1'b0;
         end
         if (wr_en && !secure)
            ctl_q[CTRL_W-1:1] <= wbits[CTRL_W-1:1];
      end
   end

endmodule

// File: rtl/dbgap_rdmux.sv
module dbgap_rdmux
   import dbgap_pkg::*;
#(
   parameter int          DW       = 32,
   parameter logic [31:0] ID_VALUE = 32'h001C_0000
) (
   input  regkind_t          kind,
   input  logic [CTRL_W-1:0] ctl_q,
   input  logic              erase_ack,
   input  logic              secure,
   output logic [DW-1:0]     rd_word
);

   always_comb begin
      rd_word = '0;
      unique case (kind)
         RK_STAT: rd_word[1:0]        = {secure, erase_ack};
         RK_CTRL: rd_word[CTRL_W-1:0] = ctl_q;
         RK_ID:   rd_word             = ID_VALUE[DW-1:0];
         default: rd_word             = '0;
      endcase
   end

endmodule

// File: rtl/dbgap_regs.sv
module dbgap_regs
   import dbgap_pkg::*;
#(
   parameter int          DW        = 32,
   parameter logic [7:0]  AP_ID     = 8'h01,
   parameter logic [31:0] ID_VALUE  = 32'h001C_0000,
   parameter bit          READ_REG  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc_valid,
   input  logic          acc_rnw,
   input  logic [7:0]    ap_sel,
   input  logic [3:0]    bank_sel,
   input  logic [1:0]    word_addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic          secure,
   input  logic          erase_allow,
   input  logic          erase_ack,
   input  logic          erase_done,
   output logic          erase_req,
   output logic          dbg_disable,
   output logic          halt_req
);

   localparam int ID_BITS = 32;

   if (DW != ID_BITS) begin : g_bad_dw
      $error("dbgap_regs: DW must be 32");
   end

   regkind_t          kind;
   logic              rd_en;
   logic              ctrl_wr;
   logic [CTRL_W-1:0] ctl_q;
   logic              erase_pend;
   logic [DW-1:0]     rd_word;

   dbgap_decode #(.AP_ID(AP_ID)) u_dec (
      .acc_valid (acc_valid),
      .acc_rnw   (acc_rnw),
      .ap_sel    (ap_sel),
      .bank_sel  (bank_sel),
      .word_addr (word_addr),
      .kind      (kind),
      .rd_en     (rd_en),
      .ctrl_wr   (ctrl_wr)
   );

   dbgap_ctrl u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (ctrl_wr),
      .wbits       (wdata[CTRL_W-1:0]),
      .secure      (secure),
      .erase_allow (erase_allow),
      .erase_done  (erase_done),
      .ctl_q       (ctl_q),
      .erase_pend  (erase_pend),
      .erase_req   (erase_req)
   );

   dbgap_rdmux #(.DW(DW), .ID_VALUE(ID_VALUE)) u_mux (
      .kind      (kind),
      .ctl_q     (ctl_q),
      .erase_ack (erase_ack),
      .secure    (secure),
      .rd_word   (rd_word)
   );

   if (READ_REG) begin : g_rd_reg
      logic [DW-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     rdata_q <= '0;
         else if (rd_en) rdata_q <= rd_word;
      end
      assign rdata = rdata_q;
   end else begin : g_rd_comb
      assign rdata = rd_en ? rd_word : '0;
   end

   assign dbg_disable = ctl_q[1];
   assign halt_req    = ctl_q[2];

endmodule

// File: rtl/dbgap_regs_chk.sv
module dbgap_regs_chk #(
   parameter logic [7:0] AP_ID    = 8'h01,
   parameter bit         READ_REG = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        acc_valid,
   input logic        acc_rnw,
   input logic [7:0]  ap_sel,
   input logic [31:0] rdata,
   input logic        secure,
   input logic        erase_allow,
   input logic        erase_done,
   input logic        erase_req,
   input logic        dbg_disable,
   input logic        halt_req,
   input logic [2:0]  ctl_q,
   input logic        erase_pend
);

   // R5: request is a single-cycle pulse
   a_r5_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |=> !erase_req);

   // R5: request only follows a write made while erase is allowed
   a_r5_req_needs_allow: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> $past(acc_valid && !acc_rnw && erase_allow));

   // R6: done clears a granted erase
   a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_pend && erase_done) |=> !ctl_q[0]);

   // R7: a blocked erase holds its bit
   a_r7_blocked_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[0] && !erase_pend) |=> ctl_q[0]);

   // R8: secured device keeps debug disable and halt
   a_r8_secure_lock: assert property (@(posedge clk) disable iff (!rst_n)
      secure |=> $stable({dbg_disable, halt_req}));

   if (READ_REG) begin : g_rd
      // R3: read data holds between reads
      a_r3_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !(acc_valid && acc_rnw) |=> $stable(rdata));

      // R1: foreign access-port number reads zero
      a_r1_foreign_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_valid && acc_rnw && ap_sel != AP_ID) |=> rdata == 32'h0);
   end

endmodule

bind dbgap_regs dbgap_regs_chk #(.AP_ID(AP_ID), .READ_REG(READ_REG)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .acc_valid   (acc_valid),
   .acc_rnw     (acc_rnw),
   .ap_sel      (ap_sel),
   .rdata       (rdata),
   .secure      (secure),
   .erase_allow (erase_allow),
   .erase_done  (erase_done),
   .erase_req   (erase_req),
   .dbg_disable (dbg_disable),
   .halt_req    (halt_req),
   .ctl_q       (ctl_q),
   .erase_pend  (erase_pend)
);

// File: tb/sim_dbgap_regs.sv
module sim_dbgap_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_rnw = 1'b1;
   logic [7:0]  ap_sel = '0;
   logic [3:0]  bank_sel = '0;
   logic [1:0]  word_addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        secure = 1'b0;
   logic        erase_allow = 1'b0;
   logic        erase_ack = 1'b0;
   logic        erase_done = 1'b0;
   logic        erase_req;
   logic        dbg_disable;
   logic        halt_req;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   logic [2:0] m_ctl = '0;

   always #2 clk = ~clk;

   dbgap_regs u0 (.*);

   always @(posedge clk) if (erase_req) pulses <= pulses + 1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic access(input logic rnw, input logic [7:0] ap, input logic [3:0] bk,
                         input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      acc_valid = 1'b1; acc_rnw = rnw; ap_sel = ap; bank_sel = bk; word_addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      acc_valid = 1'b0; acc_rnw = 1'b1;
   endtask

   task automatic done_pulse();
      @(negedge clk); erase_done = 1'b1;
      @(negedge clk); erase_done = 1'b0;
   endtask

   function automatic logic [31:0] expect_rd(input logic [7:0] ap, input logic [3:0] bk,
                                             input logic [1:0] a);
      if (ap != 8'h01) return 32'h0;
      if (bk == 4'h0 && a == 2'b00) return {30'h0, secure, erase_ack};
      if (bk == 4'h0 && a == 2'b01) return {29'h0, m_ctl};
      if (bk == 4'hF && a == 2'b11) return 32'h001C_0000;
      return 32'h0;
   endfunction

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] aps [4];
      logic [31:0] held;
      aps[0] = 8'h00; aps[1] = 8'h01; aps[2] = 8'h02; aps[3] = 8'hFF;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 rdata", rdata, 32'h0);
      chk("R9 outputs", {29'h0, erase_req, dbg_disable, halt_req}, 32'h0);
      rst_n = 1'b1;
      access(1'b1, 8'h01, 4'h0, 2'b01, 0);
      chk("R9 ctrl", rdata, 32'h0);

      // R2 identification word
      access(1'b1, 8'h01, 4'hF, 2'b11, 0);
      chk("R2 id", rdata, 32'h001C_0000);
      // R3 hold across idle cycles
      held = rdata;
      repeat (5) @(negedge clk);
      chk("R3 hold", rdata, held);

      // R8 unlocked write
      access(1'b0, 8'h01, 4'h0, 2'b01, 32'h6);
      m_ctl = 3'b110;
      chk("R8 outputs set", {30'h0, dbg_disable, halt_req}, 32'h3);
      secure = 1'b1;
      access(1'b0, 8'h01, 4'h0, 2'b01, 32'h0);
      chk("R8 locked outputs", {30'h0, dbg_disable, halt_req}, 32'h3);
      access(1'b1, 8'h01, 4'h0, 2'b01, 0);
      chk("R8 locked ctrl", rdata, 32'h6);

      // R1 R2 R4 read sweep
      erase_ack = 1'b1;
      for (int i = 0; i < 4; i++)
         for (int b = 0; b < 16; b++)
            for (int a = 0; a < 4; a++) begin
               access(1'b1, aps[i], 4'(b), 2'(a), 0);
               chk("R1 R2 R4 sweep", rdata, expect_rd(aps[i], 4'(b), 2'(a)));
            end

      // R1 R4 write sweep: every location but control, writes ignored
      secure = 1'b0; erase_allow = 1'b1; erase_ack = 1'b0;
      for (int i = 0; i < 4; i++)
         for (int b = 0; b < 16; b++)
            for (int a = 0; a < 4; a++)
               if (!(aps[i] == 8'h01 && b == 0 && a == 1))
                  access(1'b0, aps[i], 4'(b), 2'(a), 32'hFFFF_FFFF);
      access(1'b1, 8'h01, 4'h0, 2'b01, 0);
      chk("R1 ctrl untouched", rdata, 32'h6);
      access(1'b1, 8'h01, 4'h0, 2'b00, 0);
      chk("R4 status mirror", rdata, 32'h0);
      chk("R1 no erase pulse", pulses, 0);

      // R5 erase while secured
      secure = 1'b1;
      access(1'b0, 8'h01, 4'h0, 2'b01, 32'h1);
      m_ctl = 3'b111;
      chk("R5 pulse high", {31'h0, erase_req}, 32'h1);
      @(negedge clk);
      chk("R5 pulse low", {31'h0, erase_req}, 32'h0);
      access(1'b1, 8'h01, 4'h0, 2'b01, 0);
      chk("R5 bit set", rdata, 32'h7);
      // R6 write 0 / write 1 again
      access(1'b0, 8'h01, 4'h0, 2'b01, 32'h0);
      access(1'b0, 8'h01, 4'h0, 2'b01, 32'h1);
      access(1'b1, 8'h01, 4'h0, 2'b01, 0);
      chk("R6 still set", rdata, 32'h7);
      chk("R6 single request", pulses, 1);
      done_pulse();
      access(1'b1, 8'h01, 4'h0, 2'b01, 0);
      chk("R6 cleared by done", rdata, 32'h6);

      // R7 blocked erase
      erase_allow = 1'b0;
      access(1'b0, 8'h01, 4'h0, 2'b01, 32'h1);
      chk("R7 no pulse", pulses, 1);
      done_pulse();
      repeat (3) @(negedge clk);
      access(1'b1, 8'h01, 4'h0, 2'b01, 0);
      chk("R7 stays set", rdata, 32'h7);

      // R9 reset clears
      rst_n = 1'b0;
      @(negedge clk);
      chk("R9 reset outputs", {29'h0, erase_req, dbg_disable, halt_req}, 32'h0);
      chk("R9 reset rdata", rdata, 32'h0);
      rst_n = 1'b1;
      m_ctl = 3'b000;
      access(1'b1, 8'h01, 4'h0, 2'b01, 0);
      chk("R9 ctrl after reset", rdata, 32'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule